// File: doc/BRIEF.md
# Output Supply Fault Monitor with Overcurrent Timer and Interrupt

This block watches the digital protection flags of a switched output supply for a satellite down-converter: an overcurrent comparator, a thermal shutdown flag, an input undervoltage flag and a pair of power-good comparators with separate set and clear thresholds. Each flag passes through a two-flop synchroniser. A millisecond tick drives an overcurrent disable timer. The block keeps a one-byte status word that the serial slave returns on a read. It drives an active-low interrupt line and decides the enable sent to the output regulator.

Latched faults stay visible until the master has read the status and the condition has also gone away. The serial slave sends three single-cycle strobes. The first marks the resample point at the ninth clock of a status read. The second marks recognition of this device's address with the read bit set, and it releases the interrupt. The third marks the end of a control write, and at that point the output may turn on again.

Top module: `lnbFaultMon`

## Requirements
- R1: After reset the status byte is 0x81 (undervoltage and disabled bits set), the interrupt output is low (active) and the output enable is low.
- R2: Status byte fields are: bit 7 undervoltage, bit 6 thermal shutdown, bit 4 power not good, bit 2 overcurrent, bit 0 output disabled. Bits 5, 3 and 1 always read 0. A value of 0x00 means a healthy, enabled output.
- R3: While the synchronised overcurrent flag is high, the timer counts millisecond ticks. On the 48th consecutive tick it sets the overcurrent bit and the disabled bit, and it turns the output off. A drop of the flag restarts the count from zero.
- R4: The thermal and undervoltage bits are latched. They stay set after the condition goes away. A read-done strobe leaves each one set only if its condition is still present.
- R5: A read-done strobe clears the overcurrent bit whether or not the overcurrent flag is still high.
- R6: The output turns on only on a write-done strobe, with the enable control bit at 1 and no latched fault bit. An enable control bit of 0 turns the output off and sets the disabled bit on the next clock.
- R7: A fault turns the output off. The output then stays off, and no write-done strobe turns it on while a fault bit is still latched.
- R8: The power-not-good bit is not latched. It sets when the output is on and the below-threshold flag is high. It clears when the above-threshold flag is high, holds when neither flag is high, and is forced to 0 while the output is off.
- R9: The interrupt asserts on a rising thermal or undervoltage flag and on an overcurrent trip. Changes of the disabled bit or the power-not-good bit never assert it.
- R10: A read-address strobe releases the interrupt on the next clock. A new fault in the same cycle wins.
- R11: A change on a fault flag input reaches the status byte on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset (power-on) |
| ocFlag | input | 1 | Overcurrent comparator flag, asynchronous |
| tsdFlag | input | 1 | Thermal shutdown flag, asynchronous |
| uvFlag | input | 1 | Input undervoltage flag, asynchronous |
| pngBelow | input | 1 | Output below the power-good set threshold, asynchronous |
| pngAbove | input | 1 | Output above the power-good clear threshold, asynchronous |
| msTick | input | 1 | One-cycle pulse each millisecond |
| enbBit | input | 1 | Output enable control bit from the control register |
| writeDone | input | 1 | One-cycle strobe at the end of a control write |
| readAddrHit | input | 1 | One-cycle strobe on read-address recognition |
| readDone | input | 1 | One-cycle strobe at the ninth clock of a status read |
| statusByte | output | 8 | Status byte returned on reads |
| irqN | output | 1 | Interrupt request, active low (open-drain pull-down) |
| outEnable | output | 1 | Enable to the output regulator |

## Verification
The results have different latencies. A change on any fault or power-good flag shows in the status byte three rising edges later, because two synchroniser flops and the status register lie on its path. Each strobe and tick acts on the rising edge during which it is high. The bench drives every input on a falling edge and holds strobes and ticks for exactly one cycle. It then samples on a later falling edge, one edge after a strobe or tick and four edges after a flag change. The check for R11 samples on both sides of the third edge.

// File: rtl/lnbFaultPkg.sv
package lnbFaultPkg;

  // Status byte bit positions (decoded by the serial slave on reads)
  localparam int DIS_POS = 0;
  localparam int OCP_POS = 2;
  localparam int PNG_POS = 4;
  localparam int TSD_POS = 6;
  localparam int UV_POS  = 7;

  // Indices into the synchronised flag vector
  localparam int IDX_OC    = 0;
  localparam int IDX_TSD   = 1;
  localparam int IDX_UV    = 2;
  localparam int IDX_BELOW = 3;
  localparam int IDX_ABOVE = 4;
  localparam int NUM_FLAGS = 5;

  // Strobes from the control side to the status datapath
  typedef struct packed {
    logic ocTrip;    // overcurrent timer expired
    logic tsdRise;   // new thermal fault
    logic uvRise;    // new undervoltage fault
    logic resample;  // ninth clock of a status read
    logic irqClear;  // read address recognised
    logic enWrite;   // end of a control write
  } faultStrobeT;

endpackage

// File: rtl/flagSync.sv
module flagSync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/faultCtrl.sv
module faultCtrl
  import lnbFaultPkg::*;
#(
  parameter int OC_LIMIT_MS = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ocSync,
  input  logic        tsdSync,
  input  logic        uvSync,
  input  logic        msTick,
  input  logic        readDone,
  input  logic        readAddrHit,
  input  logic        writeDone,
  output faultStrobeT strobes
);

  localparam int CNT_W = $clog2(OC_LIMIT_MS + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(OC_LIMIT_MS);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(OC_LIMIT_MS - 1);

  logic [CNT_W-1:0] ocCnt;
  logic             tsdPrev;
  logic             uvPrev;

  // Overcurrent duration counter: restarts when the flag drops, saturates at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocCnt <= '0;
    end else if (!ocSync) begin
      ocCnt <= '0;
    end else if (msTick && ocCnt != LIMIT_C) begin
      ocCnt <= ocCnt + 1'b1;
    end
  end

  // Previous synchronised values for rising-edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsdPrev <= 1'b0;
      uvPrev  <= 1'b0;
    end else begin
      tsdPrev <= tsdSync;
      uvPrev  <= uvSync;
    end
  end

  always_comb begin
    strobes.ocTrip   = ocSync && msTick && (ocCnt == LAST_C);
    strobes.tsdRise  = tsdSync && !tsdPrev;
    strobes.uvRise   = uvSync && !uvPrev;
    strobes.resample = readDone;
    strobes.irqClear = readAddrHit;
    strobes.enWrite  = writeDone;
  end

  AST_TIMER_CAP: assert property (@(posedge clk) disable iff (!rstN)
    ocCnt <= LIMIT_C); // R3
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    !ocSync |=> (ocCnt == '0)); // R3

endmodule

// File: rtl/statusPath.sv
module statusPath
  import lnbFaultPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  faultStrobeT strobes,
  input  logic        tsdSync,
  input  logic        uvSync,
  input  logic        belowSync,
  input  logic        aboveSync,
  input  logic        enbBit,
  output logic [7:0]  statusByte,
  output logic        irqActive,
  output logic        outEnable
);

  logic ocpBit;
  logic tsdBit;
  logic uvBit;
  logic pngBit;
  logic enReg;
  logic anyLatched;
  logic killNow;
  logic irqSet;

  assign anyLatched = ocpBit | tsdBit | uvBit;
  assign killNow    = strobes.ocTrip | tsdSync | uvSync;
  assign irqSet     = strobes.ocTrip | strobes.tsdRise | strobes.uvRise;

  // Overcurrent: set by the timer, cleared at every resample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  ocpBit <= 1'b0;
    else if (strobes.ocTrip)    ocpBit <= 1'b1;
    else if (strobes.resample)  ocpBit <= 1'b0;
  end

  // Thermal and undervoltage: sticky, resampled against the live condition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsdBit <= 1'b0;
      uvBit  <= 1'b1;
    end else if (strobes.resample) begin
      tsdBit <= tsdSync;
      uvBit  <= uvSync;
    end else begin
      tsdBit <= tsdBit | tsdSync;
      uvBit  <= uvBit | uvSync;
    end
  end

  // Output enable: killed by faults or ENB low, restored only by a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    enReg <= 1'b0;
    else if (killNow || !enbBit)                  enReg <= 1'b0;
    else if (strobes.enWrite && !anyLatched)      enReg <= 1'b1;
  end

  // Power-not-good with hysteresis, forced low while the output is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pngBit <= 1'b0;
    else if (!enReg)    pngBit <= 1'b0;
    else if (belowSync) pngBit <= 1'b1;
    else if (aboveSync) pngBit <= 1'b0;
  end

  // Interrupt: asserted at power-on and on new faults, released by a read address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 irqActive <= 1'b1;
    else if (irqSet)           irqActive <= 1'b1;
    else if (strobes.irqClear) irqActive <= 1'b0;
  end

  always_comb begin
    statusByte          = '0;
    statusByte[DIS_POS] = ~enReg;
    statusByte[OCP_POS] = ocpBit;
    statusByte[PNG_POS] = pngBit;
    statusByte[TSD_POS] = tsdBit;
    statusByte[UV_POS]  = uvBit;
  end

  assign outEnable = enReg;

  AST_OC_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ocTrip |=> (ocpBit && !enReg)); // R3
  AST_OCP_RESAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.resample && !strobes.ocTrip) |=> !ocpBit); // R5
  AST_TSD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (tsdBit && !strobes.resample) |=> tsdBit); // R4
  AST_UV_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (uvBit && !strobes.resample) |=> uvBit); // R4
  AST_STAY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!enReg && !strobes.enWrite) |=> !enReg); // R7
  AST_PNG_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |=> !pngBit); // R8
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.irqClear && !irqSet) |=> !irqActive); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqActive) |-> $past(irqSet)); // R9

endmodule

// File: rtl/lnbFaultMon.sv
module lnbFaultMon
  import lnbFaultPkg::*;
#(
  parameter int OC_LIMIT_MS = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ocFlag,
  input  logic       tsdFlag,
  input  logic       uvFlag,
  input  logic       pngBelow,
  input  logic       pngAbove,
  input  logic       msTick,
  input  logic       enbBit,
  input  logic       writeDone,
  input  logic       readAddrHit,
  input  logic       readDone,
  output logic [7:0] statusByte,
  output logic       irqN,
  output logic       outEnable
);

  logic [NUM_FLAGS-1:0] rawFlags;
  logic [NUM_FLAGS-1:0] syncFlags;
  faultStrobeT          strobes;
  logic                 irqActive;

  always_comb begin
    rawFlags            = '0;
    rawFlags[IDX_OC]    = ocFlag;
    rawFlags[IDX_TSD]   = tsdFlag;
    rawFlags[IDX_UV]    = uvFlag;
    rawFlags[IDX_BELOW] = pngBelow;
    rawFlags[IDX_ABOVE] = pngAbove;
  end

  flagSync #(
    .WIDTH  (NUM_FLAGS),
    .STAGES (SYNC_STAGES)
  ) i_flagSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawFlags),
    .syncOut (syncFlags)
  );

  faultCtrl #(
    .OC_LIMIT_MS (OC_LIMIT_MS)
  ) i_faultCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .ocSync      (syncFlags[IDX_OC]),
    .tsdSync     (syncFlags[IDX_TSD]),
    .uvSync      (syncFlags[IDX_UV]),
    .msTick      (msTick),
    .readDone    (readDone),
    .readAddrHit (readAddrHit),
    .writeDone   (writeDone),
    .strobes     (strobes)
  );

  statusPath i_statusPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tsdSync    (syncFlags[IDX_TSD]),
    .uvSync     (syncFlags[IDX_UV]),
    .belowSync  (syncFlags[IDX_BELOW]),
    .aboveSync  (syncFlags[IDX_ABOVE]),
    .enbBit     (enbBit),
    .statusByte (statusByte),
    .irqActive  (irqActive),
    .outEnable  (outEnable)
  );

  assign irqN = ~irqActive;

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(readDone) |-> (statusByte[5] == 1'b0 && statusByte[3] == 1'b0 && statusByte[1] == 1'b0)); // R2
  AST_ON_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    outEnable |-> (statusByte[OCP_POS] == 1'b0 && statusByte[DIS_POS] == 1'b0)); // R6

endmodule

// File: tb/test_lnbFaultMon.sv
module test_lnbFaultMon;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ocFlag = 1'b0, tsdFlag = 1'b0, uvFlag = 1'b0;
  logic       pngBelow = 1'b0, pngAbove = 1'b0;
  logic       msTick = 1'b0, enbBit = 1'b0;
  logic       writeDone = 1'b0, readAddrHit = 1'b0, readDone = 1'b0;
  logic [7:0] statusByte;
  logic       irqN, outEnable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lnbFaultMon i_lnbFaultMon (
    .clk, .rstN, .ocFlag, .tsdFlag, .uvFlag, .pngBelow, .pngAbove,
    .msTick, .enbBit, .writeDone, .readAddrHit, .readDone,
    .statusByte, .irqN, .outEnable
  );

  function automatic logic [7:0] mk(logic uv, logic tsd, logic png, logic ocp, logic dis);
    return {uv, tsd, 1'b0, png, 1'b0, ocp, 1'b0, dis};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulseRead();  readDone = 1'b1;    step(1); readDone = 1'b0;    endtask
  task automatic pulseAddr();  readAddrHit = 1'b1; step(1); readAddrHit = 1'b0; endtask
  task automatic pulseWrite(); writeDone = 1'b1;   step(1); writeDone = 1'b0;   endtask
  task automatic pulseTick();  msTick = 1'b1;      step(1); msTick = 1'b0; step(1); endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 / R2: reset state
    chk("R1 status", statusByte, 8'h81);
    chk("R1 irqN", irqN, 0);
    chk("R1 outEnable", outEnable, 0);

    // R10: address strobe releases interrupt
    pulseAddr();
    chk("R10 irq release", irqN, 1);
    // R4: undervoltage cleared at read since condition gone
    pulseRead();
    chk("R4 uv cleared on read", statusByte, 8'h01);
    // R6: enable by write
    enbBit = 1'b1;
    pulseWrite();
    chk("R6 enabled", outEnable, 1);
    chk("R6 status healthy", statusByte, 8'h00);

    // R8: power-good hysteresis sweep
    pngBelow = 1'b1; step(4);
    chk("R8 png set", statusByte, mk(0,0,1,0,0));
    pngBelow = 1'b0; step(4);
    chk("R8 png hold", statusByte, mk(0,0,1,0,0));
    pngAbove = 1'b1; step(4);
    chk("R8 png clear", statusByte, mk(0,0,0,0,0));
    chk("R9 png no irq", irqN, 1);

    // R6 / R9 / R8: ENB low disables
    enbBit = 1'b0; step(1);
    chk("R6 enb low off", outEnable, 0);
    chk("R6 dis set", statusByte, mk(0,0,0,0,1));
    chk("R9 dis no irq", irqN, 1);
    pngAbove = 1'b0; pngBelow = 1'b1; step(4);
    chk("R8 png forced off", statusByte, mk(0,0,0,0,1));
    pngBelow = 1'b0; pngAbove = 1'b1;
    enbBit = 1'b1;
    pulseWrite();
    chk("R6 re-enable", outEnable, 1);

    // R11: three-edge latency of a flag input
    tsdFlag = 1'b1;
    step(2);
    chk("R11 not yet", statusByte[6], 0);
    step(1);
    chk("R11 latched at third edge", statusByte[6], 1);
    tsdFlag = 1'b0; step(4);
    pulseAddr(); pulseRead(); pulseWrite();
    chk("R6 recovered", statusByte, 8'h00);

    // R4 / R7 / R9 / R10: sweep fault combos and persistence at read
    for (int c = 1; c < 4; c++) begin
      for (int k = 0; k < 4; k++) begin
        if ((k & ~c) != 0) continue;
        tsdFlag = c[0]; uvFlag = c[1]; step(4);
        chk("R9 fault irq", irqN, 0);
        chk("R7 fault off", outEnable, 0);
        chk("R4 latched", statusByte, mk(c[1], c[0], 0, 0, 1));
        pulseWrite();
        chk("R7 write blocked", outEnable, 0);
        tsdFlag = k[0]; uvFlag = k[1]; step(4);
        chk("R4 sticky", statusByte, mk(c[1], c[0], 0, 0, 1));
        pulseAddr();
        chk("R10 release", irqN, 1);
        pulseRead();
        chk("R4 resample", statusByte, mk(k[1], k[0], 0, 0, 1));
        tsdFlag = 1'b0; uvFlag = 1'b0; step(4);
        pulseRead(); pulseWrite();
        chk("R6 recover", statusByte, 8'h00);
        chk("R6 recover enable", outEnable, 1);
      end
    end

    // R3: overcurrent timer with restart
    ocFlag = 1'b1; step(3);
    for (int t = 0; t < 47; t++) pulseTick();
    chk("R3 no trip at 47", statusByte, 8'h00);
    ocFlag = 1'b0; step(3);
    ocFlag = 1'b1; step(3);
    for (int t = 0; t < 47; t++) pulseTick();
    chk("R3 restart no trip", statusByte, 8'h00);
    chk("R3 still on", outEnable, 1);
    pulseTick();
    chk("R3 trip status", statusByte, mk(0,0,0,1,1));
    chk("R3 trip off", outEnable, 0);
    chk("R9 trip irq", irqN, 0);
    pulseAddr();
    chk("R10 release after trip", irqN, 1);
    pulseWrite();
    chk("R7 blocked by ocp", outEnable, 0);
    // R5: cleared at read although flag still high
    pulseRead();
    chk("R5 ocp cleared", statusByte, mk(0,0,0,0,1));
    ocFlag = 1'b0; step(4);
    pulseWrite();
    chk("R6 enable after ocp", outEnable, 1);
    chk("R6 healthy after ocp", statusByte, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule